// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block is a synchronous single-port memory whose address, control and data paths all run through a fixed two-stage pipeline. Read data leaves the block two clocks after its command cycle, and write data enters the block two clocks after its command cycle. Because both directions share the same latency, a write may follow a read on the very next clock, and the reverse also holds, with no idle cycle on the data buses.

Each command cycle presents an address, a direction select, a load-or-advance control, three chip-enable inputs, a clock-enable input and one write enable per byte lane. A load cycle starts a new operation at the presented address. An advance cycle steps a two-bit burst counter on the two lowest address bits and repeats the direction of the last load. Output enable gates the read data, and a separate valid flag marks when that data is present. A clock-enable stall freezes the entire pipeline.

Top module: `zt_burst_sram`

## Requirements
- R1: A cycle with `clk_en_n` low, `adv_ld` low and the chip selected starts a new operation at `addr`. The operation is a read when `rw_n` is 1 and a write when `rw_n` is 0.
- R2: On a cycle with `clk_en_n` low and `adv_ld` high, the block ignores `addr`, `rw_n` and the chip enables. The operation goes to the previous location with address bits [1:0] incremented modulo 4, bits above 1 unchanged, in the direction of the last load.
- R3: Data read for a command accepted in effective cycle n appears on `dout` with `dout_valid` high during effective cycle n+2. Cycles with `clk_en_n` high are not counted.
- R4: A write accepted in effective cycle n takes `din` in effective cycle n+2. Byte lane i covers bits [9i+8:9i], and the `lane_we_n` bit i sampled in the command cycle must be 0 for that lane to be written.
- R5: The chip is selected only when `en_a_n`=0, `en_b_n`=0 and `en_c`=1. A load cycle with any other combination is a no-op: nothing is written, and `dout_valid` stays low two cycles later. Advances that follow such a load are also no-ops.
- R6: While `clk_en_n` is 1, no pipeline stage and no burst position changes, read data holds, and no location is written.
- R7: While `oe_n` is 1, `dout_valid` is 0 and `dout` is all zeros. `oe_n` has no effect on writes.
- R8: Commands may be issued on every clock with no gap. A read issued on the clock right after a write to the same address returns the newly written lanes.
- R9: While `rst_n` is low, `dout_valid` is 0 and `dout` is zero. After reset, the pipeline holds no-ops, and advance cycles issued before any load are no-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls everything |
| en_a_n | input | 1 | Active-low chip enable |
| en_b_n | input | 1 | Second active-low chip enable |
| en_c | input | 1 | Active-high chip enable |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| rw_n | input | 1 | 1 = read, 0 = write (load cycles only) |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Active-low byte-lane write enables |
| oe_n | input | 1 | Active-low output enable |
| din | input | DATA_W | Write data, taken two cycles after command |
| dout | output | DATA_W | Read data, zero when not valid |
| dout_valid | output | 1 | Read data present on `dout` |

## Verification
The assertions check on every cycle that a stall freezes both stages and the read register and blocks all lane writes, and that output enable masks the output. They also check that an advance steps only the two low address bits with the direction kept, that a deselected load enters as a no-op, that a lane write occurs only for a write in the second stage, and that a read in the first stage yields read data on the next edge. The actual data values, which need a reference memory, are shown only by the bench scenarios. Those scenarios cover the wrapped burst order, partial lane merging, same-address read-after-write forwarding, write data timing across a stall, and the no-op behaviour after deselect and after reset.

// File: rtl/zt_pkg.sv
`timescale 1ns/1ps
package zt_pkg;
  typedef enum logic [1:0] {OP_NOP = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  // All three enables must agree for the chip to be selected
  function automatic logic chip_selected(input logic a_n, input logic b_n, input logic c);
    return !a_n && !b_n && c;
  endfunction

  // Linear two-bit burst step, wrapping modulo four
  function automatic logic [1:0] burst_next(input logic [1:0] cur);
    return cur + 2'd1;
  endfunction
endpackage

// File: rtl/zt_cmd_ctrl.sv
`timescale 1ns/1ps
module zt_cmd_ctrl
  import zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              en_a_n,
  input  logic              en_b_n,
  input  logic              en_c,
  input  logic              advance,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LANES-1:0]  lane_off,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_lane_off,
  output logic              sel_ok
);
  assign sel_ok = chip_selected(en_a_n, en_b_n, en_c);

  // Stage 1: command capture and burst position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op       <= OP_NOP;
      s1_addr     <= '0;
      s1_lane_off <= '1;
    end else if (!hold) begin
      s1_lane_off <= lane_off;
      if (!advance) begin
        s1_op   <= !sel_ok ? OP_NOP : (rd_sel ? OP_RD : OP_WR);
        s1_addr <= addr_in;
      end else begin
        s1_addr <= {s1_addr[ADDR_W-1:2], burst_next(s1_addr[1:0])};
      end
    end
  end
endmodule

// File: rtl/zt_pipe.sv
`timescale 1ns/1ps
module zt_pipe
  import zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lane_off,
  output op_e               out_op,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_lane_off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_op       <= OP_NOP;
      out_addr     <= '0;
      out_lane_off <= '1;
    end else if (!hold) begin
      out_op       <= in_op;
      out_addr     <= in_addr;
      out_lane_off <= in_lane_off;
    end
  end
endmodule

// File: rtl/zt_store.sv
`timescale 1ns/1ps
module zt_store
  import zt_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  op_e               rd_op,
  input  logic [ADDR_W-1:0] rd_addr,
  input  op_e               wr_op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lane_off,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  lane_wr,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_live
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] fwd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_wr[g] = !hold && (wr_op == OP_WR) && !wr_lane_off[g];
    // Same-edge write to the read address is forwarded lane by lane
    assign fwd[g*LANE_W +: LANE_W] = (lane_wr[g] && (wr_addr == rd_addr))
                                     ? wdata[g*LANE_W +: LANE_W]
                                     : mem[rd_addr][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (lane_wr[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      rd_live <= 1'b0;
    end else if (!hold) begin
      rd_live <= (rd_op == OP_RD);
      if (rd_op == OP_RD) rd_q <= fwd;
    end
  end
endmodule

// File: rtl/zt_burst_sram.sv
`timescale 1ns/1ps
module zt_burst_sram
  import zt_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              en_a_n,
  input  logic              en_b_n,
  input  logic              en_c,
  input  logic              adv_ld,
  input  logic              rw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  op_e               st1_op, st2_op;
  logic [ADDR_W-1:0] st1_addr, st2_addr;
  logic [LANES-1:0]  st1_lane_off, st2_lane_off, lane_wr;
  logic [DATA_W-1:0] rd_q;
  logic              rd_live, sel_ok;

  zt_cmd_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .hold(clk_en_n),
    .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c),
    .advance(adv_ld), .rd_sel(rw_n), .addr_in(addr), .lane_off(lane_we_n),
    .s1_op(st1_op), .s1_addr(st1_addr), .s1_lane_off(st1_lane_off), .sel_ok(sel_ok)
  );

  zt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .hold(clk_en_n),
    .in_op(st1_op), .in_addr(st1_addr), .in_lane_off(st1_lane_off),
    .out_op(st2_op), .out_addr(st2_addr), .out_lane_off(st2_lane_off)
  );

  zt_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_store (
    .clk(clk), .rst_n(rst_n), .hold(clk_en_n),
    .rd_op(st1_op), .rd_addr(st1_addr),
    .wr_op(st2_op), .wr_addr(st2_addr), .wr_lane_off(st2_lane_off),
    .wdata(din), .lane_wr(lane_wr), .rd_q(rd_q), .rd_live(rd_live)
  );

  assign dout_valid = rd_live && !oe_n;
  assign dout       = dout_valid ? rd_q : '0;
endmodule

// File: rtl/zt_burst_sram_chk.sv
`timescale 1ns/1ps
module zt_burst_sram_chk
  import zt_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              en_a_n,
  input logic              en_b_n,
  input logic              en_c,
  input logic              adv_ld,
  input logic              oe_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_valid,
  input op_e               st1_op,
  input logic [ADDR_W-1:0] st1_addr,
  input op_e               st2_op,
  input logic              rd_live,
  input logic [DATA_W-1:0] rd_q,
  input logic [LANES-1:0]  lane_wr
);
  // R2
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld) |=> (st1_addr[ADDR_W-1:2] == $past(st1_addr[ADDR_W-1:2]))
      && (st1_addr[1:0] == 2'($past(st1_addr[1:0]) + 2'd1)) && (st1_op == $past(st1_op)));

  // R5
  deselect_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && (en_a_n || en_b_n || !en_c)) |=> (st1_op == OP_NOP));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(st1_op) && $stable(st1_addr) && $stable(st2_op)
                  && $stable(rd_q) && $stable(rd_live)));

  // R6
  stall_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |-> (lane_wr == '0));

  // R7
  oe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_valid && (dout == '0)));

  // R4
  lane_write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_wr != '0) |-> (st2_op == OP_WR));

  // R3
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && st1_op == OP_RD) |=> rd_live);
endmodule

bind zt_burst_sram zt_burst_sram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .en_a_n(en_a_n), .en_b_n(en_b_n),
  .en_c(en_c), .adv_ld(adv_ld), .oe_n(oe_n), .dout(dout), .dout_valid(dout_valid),
  .st1_op(st1_op), .st1_addr(st1_addr), .st2_op(st2_op), .rd_live(rd_live),
  .rd_q(rd_q), .lane_wr(lane_wr)
);

// File: tb/zt_burst_sram_tb.sv
`timescale 1ns/1ps
module zt_burst_sram_tb;
  localparam int DW = 36, AW = 6, NL = 4, LW = 9;

  typedef struct packed {
    logic       cen_n;
    logic [2:0] sel;   // {en_a_n, en_b_n, en_c}; 3'b001 selects
    logic       adv;
    logic       rw_n;
    logic [5:0] addr;
    logic [3:0] bwe_n;
    logic       oe_n;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'b001, 1'b0, 1'b0, 6'h05, 4'b0000, 1'b0, 4'd1},
    '{1'b0, 3'b001, 1'b1, 1'b1, 6'h3F, 4'b0000, 1'b0, 4'd2},
    '{1'b0, 3'b110, 1'b1, 1'b1, 6'h3F, 4'b0000, 1'b0, 4'd2},
    '{1'b0, 3'b001, 1'b1, 1'b0, 6'h00, 4'b0000, 1'b0, 4'd2},
    '{1'b0, 3'b001, 1'b0, 1'b1, 6'h05, 4'b1111, 1'b0, 4'd8},
    '{1'b0, 3'b001, 1'b1, 1'b0, 6'h2A, 4'b0000, 1'b0, 4'd2},
    '{1'b0, 3'b001, 1'b1, 1'b0, 6'h2A, 4'b0000, 1'b0, 4'd2},
    '{1'b0, 3'b001, 1'b1, 1'b1, 6'h11, 4'b0000, 1'b0, 4'd2},
    '{1'b0, 3'b001, 1'b0, 1'b0, 6'h10, 4'b0000, 1'b0, 4'd4},
    '{1'b0, 3'b001, 1'b0, 1'b0, 6'h10, 4'b1010, 1'b0, 4'd4},
    '{1'b0, 3'b001, 1'b0, 1'b1, 6'h10, 4'b1111, 1'b0, 4'd8},
    '{1'b0, 3'b101, 1'b0, 1'b0, 6'h10, 4'b0000, 1'b0, 4'd5},
    '{1'b0, 3'b001, 1'b1, 1'b0, 6'h10, 4'b0000, 1'b0, 4'd5},
    '{1'b0, 3'b011, 1'b0, 1'b0, 6'h10, 4'b0000, 1'b0, 4'd5},
    '{1'b0, 3'b000, 1'b0, 1'b0, 6'h10, 4'b0000, 1'b0, 4'd5},
    '{1'b0, 3'b001, 1'b0, 1'b1, 6'h10, 4'b1111, 1'b0, 4'd5},
    '{1'b0, 3'b001, 1'b0, 1'b1, 6'h10, 4'b1111, 1'b0, 4'd7},
    '{1'b0, 3'b001, 1'b0, 1'b0, 6'h20, 4'b0000, 1'b0, 4'd7},
    '{1'b0, 3'b001, 1'b0, 1'b1, 6'h20, 4'b1111, 1'b1, 4'd7},
    '{1'b1, 3'b001, 1'b0, 1'b0, 6'h30, 4'b0000, 1'b0, 4'd6},
    '{1'b1, 3'b001, 1'b0, 1'b0, 6'h30, 4'b0000, 1'b1, 4'd6},
    '{1'b0, 3'b101, 1'b0, 1'b1, 6'h00, 4'b1111, 1'b0, 4'd6},
    '{1'b0, 3'b101, 1'b0, 1'b1, 6'h00, 4'b1111, 1'b0, 4'd6},
    '{1'b0, 3'b001, 1'b0, 1'b1, 6'h20, 4'b1111, 1'b0, 4'd4},
    '{1'b0, 3'b101, 1'b0, 1'b1, 6'h00, 4'b1111, 1'b0, 4'd3},
    '{1'b0, 3'b101, 1'b0, 1'b1, 6'h00, 4'b1111, 1'b0, 4'd3},
    '{1'b0, 3'b101, 1'b0, 1'b1, 6'h00, 4'b1111, 1'b0, 4'd3},
    '{1'b0, 3'b101, 1'b0, 1'b1, 6'h00, 4'b1111, 1'b0, 4'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_en_n = 1'b0, en_a_n = 1'b1, en_b_n = 1'b1, en_c = 1'b0;
  logic adv_ld = 1'b0, rw_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] lane_we_n = '1;
  logic [DW-1:0] din = '0, dout;
  logic dout_valid;

  always #10 clk = ~clk;  // 50 MHz

  zt_burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .en_a_n(en_a_n), .en_b_n(en_b_n),
    .en_c(en_c), .adv_ld(adv_ld), .rw_n(rw_n), .addr(addr), .lane_we_n(lane_we_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_valid(dout_valid)
  );

  int n_chk = 0, n_fail = 0;

  // Reference model state
  logic [DW-1:0] ref_mem [64];
  logic          p_live [2];
  logic          p_wr   [2];
  logic [5:0]    p_addr [2];
  logic [3:0]    p_bwe  [2];
  int            p_tag  [2];
  logic          m_act, m_wr, m_rdv;
  logic [5:0]    m_base;
  logic [1:0]    m_cnt;
  logic [DW-1:0] m_rd;
  int            m_rdtag;

  function automatic string tname(input int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";
      4: return "R4";  5: return "R5";  6: return "R6";
      7: return "R7";  8: return "R8";  default: return "R9";
    endcase
  endfunction

  function automatic logic [DW-1:0] din_of(input int i);
    logic [DW-1:0] d;
    for (int l = 0; l < NL; l++) d[l*LW +: LW] = 9'(i * 16 + l + 1);
    return d;
  endfunction

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 2; s++) begin
      p_live[s] = 1'b0; p_wr[s] = 1'b0; p_addr[s] = '0; p_bwe[s] = '1; p_tag[s] = 9;
    end
    m_act = 1'b0; m_wr = 1'b0; m_base = '0; m_cnt = '0; m_rdv = 1'b0; m_rd = '0; m_rdtag = 9;
  endtask

  // Effect of the coming rising edge, taken from the requirements
  task automatic model_edge(input vec_t v, input logic [DW-1:0] d);
    if (v.cen_n) return;
    if (p_live[1] && p_wr[1])
      for (int l = 0; l < NL; l++)
        if (!p_bwe[1][l]) ref_mem[p_addr[1]][l*LW +: LW] = d[l*LW +: LW];
    m_rdv = p_live[0] && !p_wr[0];
    if (m_rdv) m_rd = ref_mem[p_addr[0]];
    m_rdtag = p_tag[0];
    p_live[1] = p_live[0]; p_wr[1] = p_wr[0]; p_addr[1] = p_addr[0];
    p_bwe[1] = p_bwe[0]; p_tag[1] = p_tag[0];
    if (!v.adv) begin
      m_act = (v.sel == 3'b001); m_wr = !v.rw_n; m_base = v.addr; m_cnt = 2'd0;
    end else begin
      m_cnt = m_cnt + 2'd1;
    end
    p_live[0] = m_act; p_wr[0] = m_wr;
    p_addr[0] = {m_base[5:2], 2'(m_base[1:0] + m_cnt)};
    p_bwe[0] = v.bwe_n; p_tag[0] = int'(v.tag);
  endtask

  task automatic run_cycle(input vec_t v, input logic [DW-1:0] d);
    logic ev;
    @(negedge clk);
    clk_en_n = v.cen_n; {en_a_n, en_b_n, en_c} = v.sel; adv_ld = v.adv;
    rw_n = v.rw_n; addr = v.addr; lane_we_n = v.bwe_n; oe_n = v.oe_n; din = d;
    #1;
    ev = m_rdv && !v.oe_n;
    chk(ev ? tname(m_rdtag) : (v.oe_n ? "R7" : tname(m_rdtag)), "dout_valid", DW'(dout_valid), DW'(ev));
    chk(ev ? tname(m_rdtag) : (v.oe_n ? "R7" : tname(m_rdtag)), "dout", dout, ev ? m_rd : '0);
    model_edge(v, d);
  endtask

  localparam vec_t IDLE = '{1'b0, 3'b101, 1'b0, 1'b1, 6'h00, 4'b1111, 1'b0, 4'd9};

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R9: outputs quiet during reset
    chk("R9", "dout_valid in reset", DW'(dout_valid), '0);
    chk("R9", "dout in reset", dout, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_cycle(VECS[i], din_of(i));

    // R3: single read, exact latency checked through the model
    run_cycle('{1'b0, 3'b001, 1'b0, 1'b1, 6'h06, 4'b1111, 1'b0, 4'd3}, din_of(40));
    for (int i = 0; i < 3; i++) run_cycle(IDLE, din_of(41 + i));

    // R9: reset mid-burst clears the pipeline
    run_cycle('{1'b0, 3'b001, 1'b0, 1'b1, 6'h05, 4'b1111, 1'b0, 4'd9}, din_of(50));
    run_cycle('{1'b0, 3'b001, 1'b1, 1'b1, 6'h05, 4'b1111, 1'b0, 4'd9}, din_of(51));
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9", "dout_valid after reset", DW'(dout_valid), '0);
    chk("R9", "dout after reset", dout, '0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    // R9: advances before any load stay no-ops
    for (int i = 0; i < 4; i++)
      run_cycle('{1'b0, 3'b001, 1'b1, 1'b1, 6'h05, 4'b1111, 1'b0, 4'd9}, din_of(60 + i));
    // R2: a fresh burst after reset returns earlier written data
    run_cycle('{1'b0, 3'b001, 1'b0, 1'b1, 6'h07, 4'b1111, 1'b0, 4'd2}, din_of(70));
    run_cycle('{1'b0, 3'b001, 1'b1, 1'b0, 6'h00, 4'b0000, 1'b0, 4'd2}, din_of(71));
    for (int i = 0; i < 3; i++) run_cycle(IDLE, din_of(72 + i));

    summary();
    $finish;
  end
endmodule